// File: doc/BRIEF.md
# Dual 32-bit Interval Timer

This block holds two independent 32-bit up-counters, called the low half and the high half, behind a plain 32-bit register bus. Each half has a writable count and its own period. A shared control word picks each half's run mode: off, single-shot or auto-reload. A global configuration word holds a release bit for each half and a timer-mode field. A half counts only when it is released and the timer-mode field selects two separate 32-bit timers.

When a half's count reaches its period, the half emits a one-cycle interrupt pulse. In auto-reload mode the count then restarts from zero. In single-shot mode the count stops at the period and the half's mode field returns to off.

The low half also has an optional match register. It raises the low interrupt whenever the running low count equals the programmed value. Software sets the match to the current count plus a delta, and that sum wraps modulo 2^32. A period of all ones in auto-reload mode turns a half into a free-running 32-bit time base.

Top module: `dual_timer32`

## Requirements
- R1: After reset every register reads 0, both halves are held in reset and both interrupt outputs are low.
- R2: Register offsets are: low count 0x10, high count 0x14, low period 0x18, high period 0x1C, control 0x20, global configuration 0x24 and match 0x30. Period and match registers read back what was written. The configuration register reads back its bits 3:0. A read of any other address, or any cycle without a read strobe, returns 0.
- R3: Configuration bit 0 releases the low half and bit 1 releases the high half. While a half's bit is 0, its count is held at 0, count writes are ignored and no period event is produced, whatever its mode field holds.
- R4: Configuration bits 3:2 must equal 01 for the halves to count. With any other value, a released half keeps its count.
- R5: The mode field sits at control bits 7:6 for the low half and bits 23:22 for the high half. The encoding is 0 off, 1 single-shot, 2 auto-reload; 3 behaves as off. All other control bits read 0.
- R6: In single-shot mode, when the count equals the period the half pulses its interrupt in the following cycle. The count then stays at the period and the mode field reads 0.
- R7: In auto-reload mode, when the count equals the period the half pulses its interrupt and the count returns to 0. After a count of 0 and the enabling write at edge E, the events land at edges E+P+1, E+2(P+1), and so on.
- R8: With a period of 0xFFFFFFFF in auto-reload mode, the count wraps from 0xFFFFFFFF to 0 and keeps running.
- R9: While the low half is counting, a low count equal to the match register pulses the low interrupt in the next cycle. This also works for a match value reached after a wrap.
- R10: The two halves count and raise events independently. One write to the control word sets both mode fields.
- R11: A count write to a released half takes effect at that edge, overrides the increment and moves the next event accordingly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register byte address |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| rdata | output | DATA_W | Read data, 0 when idle or unmapped |
| irq_lo | output | 1 | Low-half event pulse (period or match) |
| irq_hi | output | 1 | High-half event pulse |

## Verification
The assertions assume that a period or count write never lands in the same cycle as the event they reason about. They also assume that no period of 0 is used in auto-reload mode, which would make the interrupt a level rather than a pulse. The stimulus writes a count only while the half is stopped, or well before the next event, and it uses periods of 5 or more. The one exception is the test that moves a running count on purpose. Every event is predicted from the cycle of the enabling write, so the scoreboard sees each pulse land on its exact edge.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
   typedef enum logic [1:0] {
      EM_OFF  = 2'd0,
      EM_ONCE = 2'd1,
      EM_LOOP = 2'd2,
      EM_RSVD = 2'd3
   } en_mode_e;

   localparam logic [1:0] TM_DUAL32 = 2'b01;

   localparam int LO_MODE_LSB = 6;
   localparam int HI_MODE_LSB = 22;

   localparam int OFS_CNT_LO = 'h10;
   localparam int OFS_CNT_HI = 'h14;
   localparam int OFS_PRD_LO = 'h18;
   localparam int OFS_PRD_HI = 'h1C;
   localparam int OFS_CTRL   = 'h20;
   localparam int OFS_CFG    = 'h24;
endpackage

// File: rtl/dtim_half.sv
module dtim_half
   import dtim_pkg::*;
#(
   parameter int W       = 32,
   parameter bit HAS_CMP = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rel,
   input  logic         tmode_ok,
   input  logic         cnt_we,
   input  logic         prd_we,
   input  logic         mode_we,
   input  logic         cmp_we,
   input  logic [W-1:0] wdata,
   input  logic [1:0]   mode_wv,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] prd_o,
   output logic [W-1:0] cmp_o,
   output logic [1:0]   mode_o,
   output logic         irq_o
);
   logic [W-1:0] cnt_q, prd_q;
   en_mode_e     mode_q;
   logic         active, prd_hit, cmp_hit, irq_q;

   assign active  = rel && tmode_ok && (mode_q == EM_ONCE || mode_q == EM_LOOP);
   assign prd_hit = active && (cnt_q == prd_q);

   generate
      if (HAS_CMP) begin : g_cmp
         logic [W-1:0] cmp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cmp_q <= '0;
            else if (cmp_we) cmp_q <= wdata;
         end
         assign cmp_hit = active && (cnt_q == cmp_q);
         assign cmp_o   = cmp_q;

         // R9: a match on the running count is followed by a low event
         a_r9_match_event : assert property (@(posedge clk) disable iff (!rst_n)
            (active && cnt_q == cmp_q) |=> irq_o);
      end else begin : g_nocmp
         logic unused_cmp_we;
         assign unused_cmp_we = cmp_we;
         assign cmp_hit = 1'b0;
         assign cmp_o   = '0;
      end
   endgenerate

   // counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!rel) begin
         cnt_q <= '0;
      end else if (cnt_we) begin
         cnt_q <= wdata;
      end else if (prd_hit) begin
         if (mode_q == EM_LOOP) cnt_q <= '0;
      end else if (active) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   // period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prd_q <= '0;
      else if (prd_we) prd_q <= wdata;
   end

   // mode field with hardware clear after a single-shot event
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mode_q <= EM_OFF;
      else if (mode_we)                         mode_q <= en_mode_e'(mode_wv);
      else if (prd_hit && mode_q == EM_ONCE)    mode_q <= EM_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= prd_hit || cmp_hit;
   end

   assign cnt_o  = cnt_q;
   assign prd_o  = prd_q;
   assign mode_o = mode_q;
   assign irq_o  = irq_q;

   // R3: a half in reset sits at zero
   a_r3_reset_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !rel |=> (cnt_o == '0));

   // R4: a wrong timer-mode freezes the count unless software writes it
   a_r4_mode_gate : assert property (@(posedge clk) disable iff (!rst_n)
      (rel && !tmode_ok && !cnt_we) |=> $stable(cnt_o));

   // R6: single-shot stops at the period and clears its mode
   a_r6_once_stop : assert property (@(posedge clk) disable iff (!rst_n)
      (active && mode_q == EM_ONCE && cnt_q == prd_q && !cnt_we && !mode_we)
      |=> (mode_o == 2'd0 && $stable(cnt_o) && irq_o));

   // R7: auto-reload returns to zero and raises the event
   a_r7_loop_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (active && mode_q == EM_LOOP && cnt_q == prd_q && !cnt_we)
      |=> (cnt_o == '0 && irq_o));

   // R1: an event only follows a cycle in which the half was counting
   a_r1_irq_cause : assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(active));
endmodule

// File: rtl/dtim_bus.sv
module dtim_bus
   import dtim_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter bit CMP_EN  = 1'b1,
   parameter int CMP_OFS = 'h30
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wdata,
   input  logic                   wr_en,
   input  logic                   rd_en,
   output logic [DATA_W-1:0]      rdata,
   input  logic [1:0][DATA_W-1:0] cnt_i,
   input  logic [1:0][DATA_W-1:0] prd_i,
   input  logic [1:0][DATA_W-1:0] cmp_i,
   input  logic [1:0][1:0]        mode_i,
   output logic [1:0]             cnt_we,
   output logic [1:0]             prd_we,
   output logic [1:0]             mode_we,
   output logic [1:0][1:0]        mode_wv,
   output logic                   cmp_we,
   output logic [1:0]             rel,
   output logic                   tmode_ok
);
   localparam int CFG_W = 4;

   logic [1:0] cfg_rel_q;
   logic [1:0] cfg_tm_q;

   logic sel_cnt_lo, sel_cnt_hi, sel_prd_lo, sel_prd_hi, sel_ctrl, sel_cfg, sel_cmp;

   assign sel_cnt_lo = (addr == ADDR_W'(OFS_CNT_LO));
   assign sel_cnt_hi = (addr == ADDR_W'(OFS_CNT_HI));
   assign sel_prd_lo = (addr == ADDR_W'(OFS_PRD_LO));
   assign sel_prd_hi = (addr == ADDR_W'(OFS_PRD_HI));
   assign sel_ctrl   = (addr == ADDR_W'(OFS_CTRL));
   assign sel_cfg    = (addr == ADDR_W'(OFS_CFG));
   assign sel_cmp    = CMP_EN && (addr == ADDR_W'(CMP_OFS));

   assign cnt_we  = {wr_en && sel_cnt_hi, wr_en && sel_cnt_lo};
   assign prd_we  = {wr_en && sel_prd_hi, wr_en && sel_prd_lo};
   assign mode_we = {2{wr_en && sel_ctrl}};
   assign mode_wv[0] = wdata[LO_MODE_LSB +: 2];
   assign mode_wv[1] = wdata[HI_MODE_LSB +: 2];
   assign cmp_we  = wr_en && sel_cmp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rel_q <= 2'b00;
         cfg_tm_q  <= 2'b00;
      end else if (wr_en && sel_cfg) begin
         cfg_rel_q <= wdata[1:0];
         cfg_tm_q  <= wdata[3:2];
      end
   end

   assign rel      = cfg_rel_q;
   assign tmode_ok = (cfg_tm_q == TM_DUAL32);

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (sel_cnt_lo)      rdata = cnt_i[0];
         else if (sel_cnt_hi) rdata = cnt_i[1];
         else if (sel_prd_lo) rdata = prd_i[0];
         else if (sel_prd_hi) rdata = prd_i[1];
         else if (sel_ctrl) begin
            rdata[LO_MODE_LSB +: 2] = mode_i[0];
            rdata[HI_MODE_LSB +: 2] = mode_i[1];
         end
         else if (sel_cfg)    rdata[CFG_W-1:0] = {cfg_tm_q, cfg_rel_q};
         else if (sel_cmp)    rdata = cmp_i[0] | cmp_i[1];
      end
   end

   // R2: an idle bus returns zero
   a_r2_idle_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));

   // R5: the control word carries nothing outside the two mode fields
   a_r5_ctrl_fields : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel_ctrl) |-> ((rdata & ~((DATA_W'(3) << LO_MODE_LSB) |
                                          (DATA_W'(3) << HI_MODE_LSB))) == '0));
endmodule

// File: rtl/dual_timer32.sv
module dual_timer32
   import dtim_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter bit CMP_EN  = 1'b1,
   parameter int CMP_OFS = 'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_lo,
   output logic              irq_hi
);
   localparam int N_HALF = 2;

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("dual_timer32: ADDR_W too small for the register map");
      end
      if (DATA_W <= HI_MODE_LSB + 1) begin : g_bad_data
         $error("dual_timer32: DATA_W too small for the control word");
      end
      if (CMP_EN && (CMP_OFS < 'h28 || (CMP_OFS % 4) != 0)) begin : g_bad_cmp
         $error("dual_timer32: match offset clashes or is misaligned");
      end
   endgenerate

   logic [N_HALF-1:0][DATA_W-1:0] cnt_v, prd_v, cmp_v;
   logic [N_HALF-1:0][1:0]        mode_v, mode_wv;
   logic [N_HALF-1:0]             cnt_we, prd_we, mode_we, rel, irq_v, cmp_we_v;
   logic                          cmp_we, tmode_ok;

   assign cmp_we_v = {1'b0, cmp_we};

   dtim_bus #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CMP_EN (CMP_EN),
      .CMP_OFS(CMP_OFS)
   ) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wdata   (wdata),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .rdata   (rdata),
      .cnt_i   (cnt_v),
      .prd_i   (prd_v),
      .cmp_i   (cmp_v),
      .mode_i  (mode_v),
      .cnt_we  (cnt_we),
      .prd_we  (prd_we),
      .mode_we (mode_we),
      .mode_wv (mode_wv),
      .cmp_we  (cmp_we),
      .rel     (rel),
      .tmode_ok(tmode_ok)
   );

   for (genvar h = 0; h < N_HALF; h++) begin : g_half
      dtim_half #(
         .W      (DATA_W),
         .HAS_CMP(CMP_EN && (h == 0))
      ) u_half (
         .clk     (clk),
         .rst_n   (rst_n),
         .rel     (rel[h]),
         .tmode_ok(tmode_ok),
         .cnt_we  (cnt_we[h]),
         .prd_we  (prd_we[h]),
         .mode_we (mode_we[h]),
         .cmp_we  (cmp_we_v[h]),
         .wdata   (wdata),
         .mode_wv (mode_wv[h]),
         .cnt_o   (cnt_v[h]),
         .prd_o   (prd_v[h]),
         .cmp_o   (cmp_v[h]),
         .mode_o  (mode_v[h]),
         .irq_o   (irq_v[h])
      );
   end

   assign irq_lo = irq_v[0];
   assign irq_hi = irq_v[1];

   // R10: a control write sets both halves' modes from their own fields
   a_r10_ctrl_both : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_CTRL)) |=>
         (mode_v[0] == $past(wdata[LO_MODE_LSB +: 2]) &&
          mode_v[1] == $past(wdata[HI_MODE_LSB +: 2])));
endmodule

// File: tb/tb_dual_timer32.sv
module tb_dual_timer32;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CNT_LO = 8'h10, A_CNT_HI = 8'h14, A_PRD_LO = 8'h18,
                          A_PRD_HI = 8'h1C, A_CTRL = 8'h20, A_CFG = 8'h24, A_CMP = 8'h30;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [31:0] rdata;
   logic        irq_lo, irq_hi;

   int n_chk = 0, n_err = 0, cyc = 0;
   bit done = 1'b0;
   int    q_lo[$], q_hi[$];
   string t_lo[$], t_hi[$];

   dual_timer32 dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
                     .rd_en(rd_en), .rdata(rdata), .irq_lo(irq_lo), .irq_hi(irq_hi));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] ctrl(input int lo, input int hi);
      return (32'(hi) << 22) | (32'(lo) << 6);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // write at the next edge; returns the cycle index seen after that edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d, output int cw);
      addr = a; wdata = d; wr_en = 1'b1;
      cw = cyc + 1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && irq_lo) begin
         n_chk++;
         if (q_lo.size() == 0) begin
            n_err++; $display("FAIL R6 low: unexpected event at %0d expected none", cyc);
         end else begin
            int e; string t;
            e = q_lo.pop_front(); t = t_lo.pop_front();
            if (e != cyc) begin
               n_err++; $display("FAIL %s low event: got cycle %0d expected %0d", t, cyc, e);
            end
         end
      end
      if (rst_n && irq_hi) begin
         n_chk++;
         if (q_hi.size() == 0) begin
            n_err++; $display("FAIL R7 high: unexpected event at %0d expected none", cyc);
         end else begin
            int e; string t;
            e = q_hi.pop_front(); t = t_hi.pop_front();
            if (e != cyc) begin
               n_err++; $display("FAIL %s high event: got cycle %0d expected %0d", t, cyc, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int cw;
      idle(3);
      // R1 reset state
      rd(A_CNT_LO, d); chk("R1 cnt_lo", d, 0);
      rd(A_CTRL, d);   chk("R1 ctrl", d, 0);
      rd(A_CFG, d);    chk("R1 cfg", d, 0);
      chk("R1 irqs", {30'b0, irq_hi, irq_lo}, 0);
      rst_n = 1'b1;
      idle(1);

      // R2 readback and unmapped reads
      wr(A_PRD_LO, 32'h0000_1234, cw); rd(A_PRD_LO, d); chk("R2 prd_lo", d, 32'h1234);
      wr(A_CMP, 32'h0000_ABCD, cw);    rd(A_CMP, d);    chk("R2 match", d, 32'hABCD);
      rd(8'h00, d); chk("R2 unmapped 0x00", d, 0);
      rd(8'h2C, d); chk("R2 unmapped 0x2C", d, 0);
      wr(A_CFG, 32'hFFFF_FFF4, cw); rd(A_CFG, d); chk("R2 cfg", d, 32'h4);

      // R3 halves held in reset
      wr(A_CTRL, ctrl(2, 2), cw);
      wr(A_CNT_LO, 32'd55, cw);
      idle(5);
      rd(A_CNT_LO, d); chk("R3 cnt held", d, 0);
      rd(A_CTRL, d);   chk("R5 ctrl fields", d, 32'h0080_0080);
      wr(A_CTRL, 32'hFF3F_FF3F, cw);
      rd(A_CTRL, d);   chk("R5 only fields read", d, 0);

      // R4 wrong timer mode
      wr(A_CFG, 32'h3, cw);
      wr(A_CNT_LO, 32'd7, cw);
      wr(A_CTRL, ctrl(2, 0), cw);
      idle(5);
      rd(A_CNT_LO, d); chk("R4 frozen", d, 7);
      wr(A_CTRL, 0, cw);
      wr(A_CFG, 32'h7, cw);

      // R5 mode 3 behaves as off
      wr(A_CTRL, ctrl(3, 0), cw);
      idle(4);
      rd(A_CNT_LO, d); chk("R5 reserved mode", d, 7);
      wr(A_CTRL, 0, cw);

      // R6 single-shot low, R7 auto-reload high, R10 independence
      wr(A_CNT_LO, 0, cw); wr(A_CNT_HI, 0, cw);
      wr(A_PRD_LO, 5, cw); wr(A_PRD_HI, 9, cw);
      q_lo.push_back(cyc + 1 + 6);  t_lo.push_back("R6");
      q_hi.push_back(cyc + 1 + 10); t_hi.push_back("R10");
      q_hi.push_back(cyc + 1 + 20); t_hi.push_back("R7");
      wr(A_CTRL, ctrl(1, 2), cw);
      idle(22);
      rd(A_CNT_LO, d); chk("R6 count stays", d, 5);
      rd(A_CTRL, d);   chk("R6 mode cleared", d, ctrl(0, 2));
      wr(A_CTRL, 0, cw);

      // R11 count write moves the event
      wr(A_CNT_HI, 0, cw); wr(A_PRD_HI, 100, cw);
      wr(A_CTRL, ctrl(0, 2), cw);
      idle(10);
      q_hi.push_back(cyc + 1 + 6); t_hi.push_back("R11");
      wr(A_CNT_HI, 95, cw);
      idle(10);
      rd(A_CNT_HI, d); chk("R11 after reload", d, 4);
      wr(A_CTRL, 0, cw);

      // R8 free-running wrap
      wr(A_PRD_HI, 32'hFFFF_FFFF, cw); wr(A_CNT_HI, 32'hFFFF_FFFD, cw);
      q_hi.push_back(cyc + 1 + 3); t_hi.push_back("R8");
      wr(A_CTRL, ctrl(0, 2), cw);
      idle(4);
      rd(A_CNT_HI, d); chk("R8 wrapped", d, 1);
      wr(A_CTRL, 0, cw);

      // R9 match on the low half
      wr(A_PRD_LO, 32'hFFFF_FFFF, cw); wr(A_CNT_LO, 0, cw); wr(A_CMP, 20, cw);
      q_lo.push_back(cyc + 1 + 21); t_lo.push_back("R9");
      wr(A_CTRL, ctrl(2, 0), cw);
      idle(25);
      rd(A_CNT_LO, d); chk("R9 count", d, 25);
      wr(A_CTRL, 0, cw);

      // R9 match after wrap (plus the R8 period event at the wrap)
      wr(A_CNT_LO, 32'hFFFF_FFFE, cw); wr(A_CMP, 3, cw);
      q_lo.push_back(cyc + 1 + 2); t_lo.push_back("R8");
      q_lo.push_back(cyc + 1 + 6); t_lo.push_back("R9");
      wr(A_CTRL, ctrl(2, 0), cw);
      idle(8);
      wr(A_CTRL, 0, cw);
      idle(5);

      chk("R7 pending high events", q_hi.size(), 0);
      chk("R9 pending low events", q_lo.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule